// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It sequences an external integrator, reference and comparator. After a start strobe it first shorts the integrator capacitor for a fixed number of cycles, so every conversion begins from zero charge. It then selects the unknown input and lets the integrator charge for exactly `N_INT` clock ticks. Finally it selects the negative reference and counts ticks from zero until the comparator reports that the integrator is back at or below zero.

The tick count at the stop point is the conversion result. A larger input stores more charge and so needs a longer discharge. Conversion time is therefore the fixed charge interval plus a discharge time that depends on the input. If the comparator never trips, the block gives up after `N_INT` discharge ticks and raises an overflow flag. The comparator is asynchronous to the block, so its output passes through a two-flop synchronizer before any decision uses it.

The result leaves the block as a one-cycle `done_o` strobe, which acts as the valid qualifier. There is no ready input and no back-pressure: the consumer must capture `result_o` and `ovf_o` on the strobe, or read them later, because both hold until the next conversion completes. The control and status pins are plain levels.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and at its release, `busy_o`, `done_o`, `ovf_o`, `int_zero_o` and `ref_sel_o` are 0 and `result_o` is 0.
- R2: A high `start_i` sampled while idle makes `busy_o` high from the next cycle. `int_zero_o` is then high for exactly `ZERO_CYC` cycles with `ref_sel_o` = 0 (0 selects the unknown input).
- R3: Right after the zeroing interval, `int_zero_o` is 0 and `ref_sel_o` stays 0 for exactly `N_INT` cycles (the charge phase).
- R4: In the discharge phase `ref_sel_o` is 1 (1 selects the negative reference) and the tick count restarts at 0. `cmp_i` = 1 means the integrator is at or below zero. The level of `cmp_i` seen in discharge cycle k-2 decides whether discharge cycle k is the last one. The cycles before discharge cycle 0 count as cycles -1 and -2. When the synchronized comparator is 1 in discharge cycle k, the conversion ends with `result_o` = k and `ovf_o` = 0.
- R5: If the synchronized comparator is still 0 in discharge cycle `N_INT`, the conversion ends with `ovf_o` = 1 and `result_o` = `N_INT`.
- R6: `done_o` is high for exactly one cycle per conversion, in the first cycle in which `busy_o` is low again. `result_o` and `ovf_o` change only at that point and then hold.
- R7: `start_i` while `busy_o` is high is ignored: it alters neither the result nor the length of the conversion in progress.
- R8: `busy_o` stays high for exactly `ZERO_CYC + N_INT + result_o + 1` cycles per conversion.
- R9: `int_zero_o` and `ref_sel_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, honoured only while idle |
| cmp_i | input | 1 | Comparator, 1 = integrator at or below zero; asynchronous |
| ref_sel_o | output | 1 | Switch select: 0 = unknown input, 1 = negative reference |
| int_zero_o | output | 1 | Integrator short control |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe (result valid) |
| result_o | output | RES_W | Discharge tick count, RES_W = clog2(N_INT+1) |
| ovf_o | output | 1 | Comparator did not trip within N_INT discharge ticks |

## Verification
The assertions make no assumption about `cmp_i`: any level sequence, including one that never trips, must still give a bounded conversion with a consistent result and flag. They do assume `start_i` is a synchronous level, so it may arrive in any phase, including repeatedly during a conversion. The bench drives the comparator from an integer integrator model updated on the clock, so its level is clean, and it pulses `start_i` for single cycles, sometimes in the middle of a conversion. Charge and reference weights are swept so that results cover zero, mid-range, the exact top code and overflow.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ZERO   = 2'd1,
    PH_RAMPUP = 2'd2,
    PH_RAMPDN = 2'd3
  } dsadc_phase_e;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dsadc_tick_cnt.sv
module dsadc_tick_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
  import dsadc_pkg::*;
#(
  parameter int N_INT    = 16,
  parameter int ZERO_CYC = 3,
  parameter int CNT_W    = 5,
  parameter int RES_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output dsadc_phase_e     phase_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] ZERO_LAST = CNT_W'(ZERO_CYC - 1);
  localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(N_INT - 1);
  localparam logic [CNT_W-1:0] DN_LIMIT  = CNT_W'(N_INT);

  dsadc_phase_e ph_q, ph_d;
  logic         fin;
  logic         done_q, ovf_q;
  logic [RES_W-1:0] res_q;

  always_comb begin
    ph_d      = ph_q;
    cnt_clr_o = 1'b0;
    fin       = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d      = PH_ZERO;
          cnt_clr_o = 1'b1;
        end
      end
      PH_ZERO: begin
        if (cnt_i == ZERO_LAST) begin
          ph_d      = PH_RAMPUP;
          cnt_clr_o = 1'b1;
        end
      end
      PH_RAMPUP: begin
        if (cnt_i == RAMP_LAST) begin
          ph_d      = PH_RAMPDN;
          cnt_clr_o = 1'b1;
        end
      end
      PH_RAMPDN: begin
        if (cmp_s_i || (cnt_i == DN_LIMIT)) begin
          ph_d = PH_IDLE;
          fin  = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign cnt_en_o = (ph_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      done_q <= fin;
      if (fin) begin
        res_q <= cnt_i[RES_W-1:0];
        ovf_q <= ~cmp_s_i;
      end
    end
  end

  assign phase_o  = ph_q;
  assign done_o   = done_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int N_INT     = 16,
  parameter int ZERO_CYC  = 3,
  parameter int SYNC_STG  = 2,
  localparam int RES_W    = $clog2(N_INT + 1),
  localparam int CNT_MAX  = (ZERO_CYC > N_INT) ? ZERO_CYC : N_INT,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             ref_sel_o,
  output logic             int_zero_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovf_o
);

  logic             cmp_s;
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt;
  dsadc_phase_e     phase;

  dsadc_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  dsadc_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .cnt_o  (cnt)
  );

  dsadc_fsm #(
    .N_INT    (N_INT),
    .ZERO_CYC (ZERO_CYC),
    .CNT_W    (CNT_W),
    .RES_W    (RES_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_s_i   (cmp_s),
    .cnt_i     (cnt),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .phase_o   (phase),
    .done_o    (done_o),
    .result_o  (result_o),
    .ovf_o     (ovf_o)
  );

  assign busy_o     = (phase != PH_IDLE);
  assign int_zero_o = (phase == PH_ZERO);
  assign ref_sel_o  = (phase == PH_RAMPDN);

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int N_INT = 16,
  parameter int RES_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ref_sel_o,
  input logic             int_zero_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic             ovf_o
);

  assert_idle_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && int_zero_o && !ref_sel_o));

  assert_dn_after_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_sel_o) |-> ($past(busy_o) && !$past(int_zero_o)));

  assert_no_overflow_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o == RES_W'(N_INT)));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ends_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(ovf_o)));

  assert_busy_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !int_zero_o && start_i) |=> !int_zero_o);

  assert_zero_sel_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_zero_o && ref_sel_o));

endmodule

bind dsadc_seq dsadc_seq_chk #(.N_INT(N_INT), .RES_W(RES_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ref_sel_o  (ref_sel_o),
  .int_zero_o (int_zero_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .ovf_o      (ovf_o)
);

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_INT      = 16;
  localparam int ZERO_CYC   = 3;
  localparam int RES_W      = $clog2(N_INT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic ref_sel, int_zero, busy, done, ovf;
  logic [RES_W-1:0] result;

  int tests = 0;
  int fails = 0;
  int vin = 0;
  int vref = 8;
  int acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsadc_seq #(.N_INT(N_INT), .ZERO_CYC(ZERO_CYC)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .cmp_i      (cmp),
    .ref_sel_o  (ref_sel),
    .int_zero_o (int_zero),
    .busy_o     (busy),
    .done_o     (done),
    .result_o   (result),
    .ovf_o      (ovf)
  );

  // Integrator model: reset by the short, charged by vin, discharged by vref.
  always @(posedge clk) begin
    if (!rst_n)        acc <= 0;
    else if (int_zero) acc <= 0;
    else if (ref_sel)  acc <= acc - vref;
    else if (busy)     acc <= acc + vin;
  end
  assign cmp = (acc <= 0);

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Discharge ticks: ceil(charge/vref) plus two synchronizer cycles; zero input stops at once.
  function automatic int raw_ticks(input int v, input int r);
    if (v == 0) return 0;
    return (v * N_INT + r - 1) / r + 2;
  endfunction

  task automatic convert(input int v, input int r, input int extra_start_at);
    int busy_n = 0, zero_n = 0, sel_n = 0, steps = 0, k, exp_res, exp_ovf;
    int prev_res;
    vin = v;
    vref = r;
    k = raw_ticks(v, r);
    exp_ovf = (k > N_INT) ? 1 : 0;
    exp_res = exp_ovf ? N_INT : k;
    prev_res = int'(result);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && steps < 500) begin
      steps++;
      if (busy) busy_n++;
      if (int_zero) zero_n++;
      if (ref_sel) sel_n++;
      if (steps == 1) check("R2 busy after start", int'(busy), 1);
      if (extra_start_at != 0 && steps == extra_start_at) start = 1'b1;
      else start = 1'b0;
      if (!done && busy && int_zero) begin
        if (ref_sel) check("R9 zero and select", 1, 0);
      end
      if (steps >= 2) begin
        if (!done && !busy) check("R6 result changed early", int'(result), prev_res);
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R2 zero cycles", zero_n, ZERO_CYC);
    check("R3 charge cycles", busy_n - zero_n - sel_n, N_INT);
    check("R4 result", int'(result), exp_res);
    check("R5 overflow flag", int'(ovf), exp_ovf);
    check("R8 busy length", busy_n, ZERO_CYC + N_INT + exp_res + 1);
    if (extra_start_at != 0) check("R7 busy length with extra start", busy_n, ZERO_CYC + N_INT + exp_res + 1);
    check("R6 busy low at done", int'(busy), 0);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
    repeat (2) @(negedge clk);
    check("R6 result held", int'(result), exp_res);
    check("R6 overflow held", int'(ovf), exp_ovf);
    check("R7 idle after extra start", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 result in reset", int'(result), 0);
    check("R1 ovf in reset", int'(ovf), 0);
    check("R1 zero ctl in reset", int'(int_zero), 0);
    check("R1 select in reset", int'(ref_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 result after reset", int'(result), 0);

    // Sweep reference weight and input charge: results from zero through overflow.
    for (int r = 3; r <= 12; r++) begin
      for (int v = 0; v <= 12; v++) begin
        convert(v, r, 0);
      end
    end

    // Start strobes inside the zeroing, charge and discharge phases.
    convert(5, 8, 2);
    convert(5, 8, 10);
    convert(7, 8, 25);
    convert(12, 4, 30);
    convert(1, 16, 21);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule